// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block tells whether each incoming interlaced video field is the first (odd, A) or the second (even, B) field of a frame. It works in the pixel clock domain. The horizontal and vertical sync inputs are first brought in through two-flip-flop synchronizers. Their rising edges are then turned into single-cycle pulses.

The horizontal pulse is delayed by a programmable amount to form the first reference pulse, H1. That amount is set by a coarse step of four clocks plus a fine phase of zero to three clocks. A line-period counter measures the clocks between successive H1 pulses. From that measurement it places a second reference pulse, H2, half a line after each H1, so the line rate is doubled. The vertical pulse gets its own programmable delay to form Vd, which lets software line the vertical edge up against H1.

When Vd arrives, the block checks which half-line interval it falls in. It then sets the field flag and holds it until the next Vd. A status output shows when a line period has been measured; until then, vertical edges are ignored.

Top module: `field_parity_det`

## Requirements
- R1: While reset is high and in the cycle after it is released, `field_odd`, `line_valid`, `ref_h1`, `ref_h2` and `v_ref` are all 0.
- R2: `ref_h1` pulses for one cycle exactly 4*`hdly_coarse` + `hdly_fine` + 3 clock cycles after the cycle in which `hsync_in` is first driven high.
- R3: `v_ref` pulses for one cycle exactly `vdly` + 3 clock cycles after the cycle in which `vsync_in` is first driven high.
- R4: The line length L is the number of clocks between two successive `ref_h1` pulses. Once it is measured, `ref_h2` pulses exactly floor(L/2) cycles after each `ref_h1`.
- R5: `line_valid` stays 0 until the second `ref_h1` after reset. It is 1 from the cycle after that pulse, and then stays 1 until reset.
- R6: If `v_ref` pulses in the interval from a `ref_h1` up to (not including) the next `ref_h2`, `field_odd` becomes 1 in the next cycle. This includes a `v_ref` in the same cycle as `ref_h1`.
- R7: If `v_ref` pulses in the interval from a `ref_h2` up to (not including) the next `ref_h1`, `field_odd` becomes 0 in the next cycle. This includes a `v_ref` in the same cycle as `ref_h2`.
- R8: `field_odd` changes only in the cycle after a `v_ref` pulse and holds its value for the rest of the field.
- R9: A `v_ref` pulse that occurs while `line_valid` is 0 has no effect on `field_odd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active high |
| vsync_in | input | 1 | Vertical sync, asynchronous, active high |
| hdly_coarse | input | HC_W (4) | Horizontal delay, in steps of four clocks |
| hdly_fine | input | HF_W (2) | Horizontal delay fine phase, 0 to 3 clocks |
| vdly | input | VD_W (12) | Vertical delay in clocks |
| ref_h1 | output | 1 | Delayed horizontal reference pulse |
| ref_h2 | output | 1 | Mid-line reference pulse |
| v_ref | output | 1 | Delayed vertical pulse |
| line_valid | output | 1 | Line period has been measured |
| field_odd | output | 1 | 1 for an A (odd) field, 0 for a B (even) field |

## Verification
The hardest cases to reach from the ports are those where the delayed vertical pulse lands in exactly the same cycle as H1 or as H2. These cases decide which half-line wins a tie. The stimulus reaches them by raising vertical sync on the same clock as horizontal sync. It then sets the vertical delay equal to the horizontal delay, or to that delay plus half a line. Because both sync paths share the same fixed latency, the two pulses coincide to the cycle. Odd line lengths are also used to exercise the rounding of the half-line position.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } half_e;

    typedef struct packed {
        logic  h1;
        logic  h2;
        logic  vd;
    } ref_pulses_t;

    function automatic half_e phase_now(input ref_pulses_t p, input half_e held);
        if (p.h1)
            return HALF_FIRST;
        else if (p.h2)
            return HALF_SECOND;
        else
            return held;
    endfunction

endpackage

// File: rtl/fpd_edge_sync.sv
module fpd_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic rise
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else
            sh <= {sh[1:0], d};
    end

    assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/fpd_pulse_delay.sv
module fpd_pulse_delay #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trig,
    input  logic [W-1:0] dly,
    output logic         pulse
);
    logic [W-1:0] rem;
    logic         busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            busy  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (trig) begin
                rem   <= dly;
                busy  <= (dly != '0);
                pulse <= (dly == '0);
            end else if (busy) begin
                rem <= rem - 1'b1;
                if (rem == W'(1)) begin
                    pulse <= 1'b1;
                    busy  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/fpd_line_doubler.sv
module fpd_line_doubler #(
    parameter int LINE_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic h1,
    output logic h2,
    output logic valid
);
    logic [LINE_W-1:0] cnt;
    logic [LINE_W-1:0] period;
    logic [LINE_W-1:0] half_len;
    logic              seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            period <= '0;
            seen   <= 1'b0;
            valid  <= 1'b0;
        end else if (h1) begin
            cnt  <= LINE_W'(1);
            seen <= 1'b1;
            if (seen) begin
                period <= cnt;
                valid  <= 1'b1;
            end
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign half_len = period >> 1;
    assign h2 = valid && (half_len != '0) && (cnt == half_len);
endmodule

// File: rtl/fpd_field_judge.sv
module fpd_field_judge
    import fpd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  ref_pulses_t refs,
    input  logic        valid,
    output logic        field_odd
);
    half_e held;
    half_e now_phase;

    assign now_phase = phase_now(refs, held);

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= HALF_FIRST;
            field_odd <= 1'b0;
        end else begin
            held <= now_phase;
            if (refs.vd && valid)
                field_odd <= (now_phase == HALF_FIRST);
        end
    end
endmodule

// File: rtl/field_parity_det.sv
module field_parity_det
    import fpd_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int HC_W   = 4,
    parameter int HF_W   = 2,
    parameter int VD_W   = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hsync_in,
    input  logic            vsync_in,
    input  logic [HC_W-1:0] hdly_coarse,
    input  logic [HF_W-1:0] hdly_fine,
    input  logic [VD_W-1:0] vdly,
    output logic            ref_h1,
    output logic            ref_h2,
    output logic            v_ref,
    output logic            line_valid,
    output logic            field_odd
);
    localparam int HD_W = HC_W + HF_W;
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] rise;
    logic [HD_W-1:0] hdly_total;
    ref_pulses_t     refs;

    assign raw_in     = {vsync_in, hsync_in};
    assign hdly_total = {hdly_coarse, hdly_fine};

    for (genvar i = 0; i < N_IN; i++) begin : g_sync
        fpd_edge_sync u_sync (
            .clk  (clk),
            .rst  (rst),
            .d    (raw_in[i]),
            .rise (rise[i])
        );
    end

    fpd_pulse_delay #(.W(HD_W)) u_hdly (
        .clk   (clk),
        .rst   (rst),
        .trig  (rise[0]),
        .dly   (hdly_total),
        .pulse (ref_h1)
    );

    fpd_pulse_delay #(.W(VD_W)) u_vdly (
        .clk   (clk),
        .rst   (rst),
        .trig  (rise[1]),
        .dly   (vdly),
        .pulse (v_ref)
    );

    fpd_line_doubler #(.LINE_W(LINE_W)) u_dbl (
        .clk   (clk),
        .rst   (rst),
        .h1    (ref_h1),
        .h2    (ref_h2),
        .valid (line_valid)
    );

    assign refs = '{h1: ref_h1, h2: ref_h2, vd: v_ref};

    fpd_field_judge u_judge (
        .clk       (clk),
        .rst       (rst),
        .refs      (refs),
        .valid     (line_valid),
        .field_odd (field_odd)
    );
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker (
    input logic clk,
    input logic rst,
    input logic ref_h1,
    input logic ref_h2,
    input logic v_ref,
    input logic line_valid,
    input logic field_odd
);
    // R2: H1 is a single-cycle pulse
    a_r2_h1_single: assert property (@(posedge clk) disable iff (rst)
        ref_h1 |=> !ref_h1);

    // R5: once measured, the line period stays valid
    a_r5_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        line_valid |=> line_valid);

    // R6: Vd coinciding with H1 selects the A field
    a_r6_tie_h1: assert property (@(posedge clk) disable iff (rst)
        (v_ref && ref_h1 && line_valid) |=> field_odd);

    // R7: Vd coinciding with H2 selects the B field
    a_r7_tie_h2: assert property (@(posedge clk) disable iff (rst)
        (v_ref && ref_h2 && !ref_h1 && line_valid) |=> !field_odd);

    // R8: the flag moves only after a Vd pulse
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !v_ref |=> $stable(field_odd));

    // R9: no field decision before the line period is known
    a_r9_ignore: assert property (@(posedge clk) disable iff (rst)
        !line_valid |=> !field_odd);
endmodule

bind field_parity_det fpd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_h1     (ref_h1),
    .ref_h2     (ref_h2),
    .v_ref      (v_ref),
    .line_valid (line_valid),
    .field_odd  (field_odd)
);

// File: tb/sim_field_parity_det.sv
module sim_field_parity_det;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic [3:0]  hdly_coarse = '0;
    logic [1:0]  hdly_fine = '0;
    logic [11:0] vdly = '0;
    logic        ref_h1, ref_h2, v_ref, line_valid, field_odd;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int hs_rise_cyc = 0, vs_rise_cyc = 0, last_h1 = 0;
    int h1gap = -1, h2gap = -1, vgap = -1;

    // columns: line length, coarse, fine, vertical delay, vsync offset in line
    localparam int NV = 11;
    localparam int VEC [NV][5] = '{
        '{64, 0, 0, 0,   5},
        '{64, 0, 0, 0,   40},
        '{64, 2, 1, 0,   5},
        '{64, 2, 1, 20,  5},
        '{64, 0, 0, 32,  0},
        '{64, 0, 3, 3,   0},
        '{100, 5, 0, 0,  30},
        '{100, 0, 0, 160, 10},
        '{101, 0, 0, 50, 0},
        '{101, 0, 0, 49, 0},
        '{64, 3, 2, 14,  0}
    };

    field_parity_det u0 (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hdly_coarse(hdly_coarse), .hdly_fine(hdly_fine), .vdly(vdly),
        .ref_h1(ref_h1), .ref_h2(ref_h2), .v_ref(v_ref),
        .line_valid(line_valid), .field_odd(field_odd)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (ref_h1) begin
            last_h1 = cyc;
            h1gap   = cyc - hs_rise_cyc;
        end
        if (ref_h2) h2gap = cyc - last_h1;
        if (v_ref)  vgap  = cyc - vs_rise_cyc;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic line(input int len, input int voff);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            hsync_in = (k < 4);
            if (k == 0) hs_rise_cyc = cyc;
            if (k == 0 && voff < 0) vsync_in = 1'b0;
            if (k == voff) begin
                vsync_in = 1'b1;
                vs_rise_cyc = cyc;
            end
        end
    endtask

    function automatic int expect_odd(input int len, input int hd, input int vd, input int off);
        int rel;
        rel = ((off + vd - hd) % len + len) % len;
        return (rel < len / 2) ? 1 : 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        hsync_in = 1'b0;
        vsync_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        do_reset();
        check("R1 field_odd after reset", field_odd, 0);
        check("R1 line_valid after reset", line_valid, 0);
        check("R1 pulses after reset", {ref_h1, ref_h2, v_ref}, 0);

        // R9: vertical edge before any line period is known
        @(negedge clk); vsync_in = 1'b1;
        repeat (20) @(negedge clk);
        vsync_in = 1'b0;
        check("R9 field_odd before valid", field_odd, 0);

        // R5: valid only after the second H1
        line(64, -1);
        check("R5 valid after one H1", line_valid, 0);
        line(64, -1);
        check("R5 valid after two H1", line_valid, 1);

        for (int v = 0; v < NV; v++) begin
            int len, hd, vd, off, exp_f, prev;
            len = VEC[v][0];
            hd  = VEC[v][1] * 4 + VEC[v][2];
            vd  = VEC[v][3];
            off = VEC[v][4];
            @(negedge clk);
            hdly_coarse = 4'(VEC[v][1]);
            hdly_fine   = 2'(VEC[v][2]);
            vdly        = 12'(vd);
            repeat (3) line(len, -1);
            line(len, off);
            repeat ((vd + hd) / len + 3) line(len, -1);
            exp_f = expect_odd(len, hd, vd, off);
            if (exp_f == 1)
                check($sformatf("R6 field vec%0d", v), field_odd, 1);
            else
                check($sformatf("R7 field vec%0d", v), field_odd, 0);
            check($sformatf("R2 h1 latency vec%0d", v), h1gap, hd + 3);
            check($sformatf("R3 vd latency vec%0d", v), vgap, vd + 3);
            check($sformatf("R4 h2 offset vec%0d", v), h2gap, len / 2);
            prev = field_odd;
            repeat (2) line(len, -1);
            check($sformatf("R8 hold vec%0d", v), field_odd, prev);
            check($sformatf("R5 valid stays vec%0d", v), line_valid, 1);
        end

        // R1: reset in mid-run clears state
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 field_odd in reset", field_odd, 0);
        check("R1 line_valid in reset", line_valid, 0);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule